// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from the host to a PS/2 device over the two open-drain bus lines. A request is first accepted on a start/ready handshake. The block then claims the bus by pulling the clock line low for a fixed inhibit interval. Next it pulls the data line low as the start bit and lets the clock float. From that point the device produces the clock. On each of its falling edges the block presents the next bit: eight data bits, an odd parity bit and a released stop bit. On the last edge it reads the acknowledge that the device drives.

The block ignores falling edges that arrive too soon. Too soon means either right after the clock is released or right after an edge that was already accepted. These come from glitches and from stale edges that the inhibit itself leaves behind. A high acknowledge, a missing edge or an out-of-range bit index makes the block release the data line and run the whole transfer again with the same byte. The number of retries is bounded by a parameter. On success it pulses `done` and returns to idle, so that a receive path can take over the bus. When the retries run out it pulses `fail` instead.

Both line inputs pass through a two-stage synchronizer. An accepted clock edge therefore acts on the outputs three clock cycles after the pin falls. All timing limits are counted in system clock cycles and set by parameters.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, and whenever idle, `ready` is 1 and `ps2ClkOe`, `ps2DataOe`, `done` and `fail` are 0.
- R2: An accepted request pulls the clock low (`ps2ClkOe`=1) for exactly INHIBIT_CYC cycles. The data line stays released during that time.
- R3: In the cycle the clock is released, the data line is pulled low as the start bit (`ps2DataOe`=1). It stays low until the first accepted falling edge.
- R4: On accepted falling edges 1 to 8 the line carries data bits 0 to 7, least significant first. `ps2DataOe` is the inverse of the bit. Each update lands three cycles after the pin falls.
- R5: On accepted edge 9 the line carries odd parity. It is released (high) when the byte holds an even number of ones and pulled low otherwise.
- R6: On accepted edge 10 the data line is released as the stop bit.
- R7: On accepted edge 11, a low data line ends the transfer. `done` pulses for one cycle, both lines are released and `ready` returns to 1.
- R8: Falling edges seen fewer than BLANK_CYC cycles after the clock is released are ignored.
- R9: Falling edges seen fewer than MIN_GAP_CYC cycles after the previous accepted edge are ignored.
- R10: A high data line on edge 11 starts a new attempt with the same byte. The data line is released and the inhibit is repeated.
- R11: A new attempt also starts when no accepted edge arrives within MAX_GAP_CYC cycles of the previous accepted edge. Before the first accepted edge the limit is FIRST_WAIT_CYC cycles, counted from the clock release.
- R12: After MAX_RETRIES retries, a further failure pulses `fail` for one cycle instead of retrying. It releases both lines, returns to idle and gives no `done`.
- R13: `startReq` and `txByte` are ignored while `ready` is 0. The byte in flight is not changed and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | Request to send `txByte`, taken when `ready` is 1 |
| txByte | input | 8 | Command byte to send |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse: device acknowledged the byte |
| fail | output | 1 | One-cycle pulse: retries exhausted |
| ps2ClkIn | input | 1 | Sensed level of the bus clock line |
| ps2DataIn | input | 1 | Sensed level of the bus data line |
| ps2ClkOe | output | 1 | 1 pulls the clock line low, 0 releases it |
| ps2DataOe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench plays the device side. It drives the clock pins on the falling system clock edge and reads the host's data bits at its own rising clock edges, eight cycles after each fall. That leaves margin past the three-cycle path from pin to `ps2DataOe`. The inhibit length is measured at run end and must equal INHIBIT_CYC. A timeout retry must raise the clock enable MAX_GAP_CYC+4 cycles after the last pin fall, or FIRST_WAIT_CYC+1 cycles after the release, within a one-cycle margin. `done` and `fail` are counted continuously and compared when each attempt ends. Every byte value is swept, and glitch, negative-acknowledge, stall and busy-request cases follow.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  // Bit positions on the bus, counted in accepted falling edges.
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned CNT_W      = 4;
  localparam logic [CNT_W-1:0] EDGE_FIRST  = 4'd1;
  localparam logic [CNT_W-1:0] EDGE_PARITY = 4'd9;
  localparam logic [CNT_W-1:0] EDGE_STOP   = 4'd10;
  localparam logic [CNT_W-1:0] EDGE_ACK    = 4'd11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_SHIFT
  } txState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadByte;
    logic clrTimer;
    logic startBit;
    logic stepBit;
    logic releaseData;
    logic clrRetry;
    logic incRetry;
  } txCtl_t;

endpackage

// File: rtl/ps2_tx_datapath.sv
module ps2_tx_datapath
  import ps2_tx_pkg::*;
#(
  parameter int unsigned TW = 8,
  parameter int unsigned RW = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  txCtl_t                 ctl,
  input  logic [DATA_BITS-1:0]   txByte,
  input  logic                   ps2ClkIn,
  input  logic                   ps2DataIn,
  output logic                   clkFall,
  output logic                   dataNow,
  output logic [TW-1:0]          timer,
  output logic [CNT_W-1:0]       bitCnt,
  output logic [RW-1:0]          retryCnt,
  output logic                   dataOe
);

  logic [1:0]           clkSync;
  logic [1:0]           dataSync;
  logic                 clkPrev;
  logic [DATA_BITS-1:0] byteHeld;
  logic [2:0]           bitIdx;
  logic                 nextOe;

  assign clkFall = clkPrev & ~clkSync[1];
  assign dataNow = dataSync[1];
  assign bitIdx  = 3'(bitCnt - EDGE_FIRST);

  // Level to pull on the next accepted edge.
  always_comb begin
    if (bitCnt >= EDGE_FIRST && bitCnt < EDGE_PARITY) begin
      nextOe = ~byteHeld[bitIdx];
    end else if (bitCnt == EDGE_PARITY) begin
      nextOe = ^byteHeld;           // parity bit is low when ones are odd
    end else begin
      nextOe = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= 2'b11;
      dataSync <= 2'b11;
      clkPrev  <= 1'b1;
      timer    <= '0;
      byteHeld <= '0;
      bitCnt   <= EDGE_FIRST;
      retryCnt <= '0;
      dataOe   <= 1'b0;
    end else begin
      clkSync  <= {clkSync[0], ps2ClkIn};
      dataSync <= {dataSync[0], ps2DataIn};
      clkPrev  <= clkSync[1];

      if (ctl.clrTimer) begin
        timer <= '0;
      end else if (timer != '1) begin
        timer <= timer + 1'b1;
      end

      if (ctl.loadByte) begin
        byteHeld <= txByte;
      end

      if (ctl.startBit) begin
        bitCnt <= EDGE_FIRST;
      end else if (ctl.stepBit) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (ctl.clrRetry) begin
        retryCnt <= '0;
      end else if (ctl.incRetry) begin
        retryCnt <= retryCnt + 1'b1;
      end

      if (ctl.startBit) begin
        dataOe <= 1'b1;
      end else if (ctl.releaseData) begin
        dataOe <= 1'b0;
      end else if (ctl.stepBit) begin
        dataOe <= nextOe;
      end
    end
  end

endmodule

// File: rtl/ps2_tx_ctrl.sv
module ps2_tx_ctrl
  import ps2_tx_pkg::*;
#(
  parameter int unsigned TW             = 8,
  parameter int unsigned RW             = 2,
  parameter int unsigned INHIBIT_CYC    = 200,
  parameter int unsigned BLANK_CYC      = 60,
  parameter int unsigned MIN_GAP_CYC    = 40,
  parameter int unsigned MAX_GAP_CYC    = 120,
  parameter int unsigned FIRST_WAIT_CYC = 20000,
  parameter int unsigned MAX_RETRIES    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             clkFall,
  input  logic             dataNow,
  input  logic [TW-1:0]    timer,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [RW-1:0]    retryCnt,
  output txCtl_t           ctl,
  output logic             ready,
  output logic             done,
  output logic             fail,
  output logic             clkOe
);

  localparam logic [TW-1:0] INH_LAST   = TW'(INHIBIT_CYC - 1);
  localparam logic [TW-1:0] BLANK_T    = TW'(BLANK_CYC);
  localparam logic [TW-1:0] MIN_GAP_T  = TW'(MIN_GAP_CYC);
  localparam logic [TW-1:0] MAX_GAP_T  = TW'(MAX_GAP_CYC);
  localparam logic [TW-1:0] FIRST_T    = TW'(FIRST_WAIT_CYC);
  localparam logic [RW-1:0] RETRY_LAST = RW'(MAX_RETRIES);

  txState_t state, stateNext;
  logic     firstEdge, holdOff, expired, edgeOk, bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign firstEdge = (bitCnt == EDGE_FIRST);
  assign holdOff   = firstEdge ? (timer < BLANK_T) : (timer < MIN_GAP_T);
  assign expired   = firstEdge ? (timer >= FIRST_T) : (timer >= MAX_GAP_T);
  assign edgeOk    = clkFall && !holdOff;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ready     = 1'b0;
    done      = 1'b0;
    fail      = 1'b0;
    clkOe     = 1'b0;
    bad       = 1'b0;

    unique case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (startReq) begin
          ctl.loadByte = 1'b1;
          ctl.clrTimer = 1'b1;
          ctl.clrRetry = 1'b1;
          stateNext    = ST_INHIBIT;
        end
      end

      ST_INHIBIT: begin
        clkOe = 1'b1;
        if (timer >= INH_LAST) begin
          ctl.startBit = 1'b1;
          ctl.clrTimer = 1'b1;
          stateNext    = ST_SHIFT;
        end
      end

      ST_SHIFT: begin
        if (expired) begin
          bad = 1'b1;
        end else if (edgeOk) begin
          if (bitCnt == EDGE_ACK) begin
            if (!dataNow) begin
              done            = 1'b1;
              ctl.releaseData = 1'b1;
              stateNext       = ST_IDLE;
            end else begin
              bad = 1'b1;
            end
          end else if (bitCnt >= EDGE_FIRST && bitCnt <= EDGE_STOP) begin
            ctl.stepBit  = 1'b1;
            ctl.clrTimer = 1'b1;
          end else begin
            bad = 1'b1;           // index out of range: lost sync
          end
        end

        if (bad) begin
          ctl.releaseData = 1'b1;
          if (retryCnt == RETRY_LAST) begin
            fail      = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.incRetry = 1'b1;
            ctl.clrTimer = 1'b1;
            stateNext    = ST_INHIBIT;
          end
        end
      end

      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2_tx_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC    = 200,
  parameter int unsigned BLANK_CYC      = 60,
  parameter int unsigned MIN_GAP_CYC    = 40,
  parameter int unsigned MAX_GAP_CYC    = 120,
  parameter int unsigned FIRST_WAIT_CYC = 20000,
  parameter int unsigned MAX_RETRIES    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] txByte,
  output logic       ready,
  output logic       done,
  output logic       fail,
  input  logic       ps2ClkIn,
  input  logic       ps2DataIn,
  output logic       ps2ClkOe,
  output logic       ps2DataOe
);

  localparam int unsigned T_MAX_A = (INHIBIT_CYC > MAX_GAP_CYC) ? INHIBIT_CYC : MAX_GAP_CYC;
  localparam int unsigned T_MAX   = (T_MAX_A > FIRST_WAIT_CYC) ? T_MAX_A : FIRST_WAIT_CYC;
  localparam int unsigned TW      = $clog2(T_MAX + 2);
  localparam int unsigned RW      = $clog2(MAX_RETRIES + 2);

  txCtl_t           ctl;
  logic             clkFall;
  logic             dataNow;
  logic [TW-1:0]    timer;
  logic [CNT_W-1:0] bitCnt;
  logic [RW-1:0]    retryCnt;

  ps2_tx_ctrl #(
    .TW            (TW),
    .RW            (RW),
    .INHIBIT_CYC   (INHIBIT_CYC),
    .BLANK_CYC     (BLANK_CYC),
    .MIN_GAP_CYC   (MIN_GAP_CYC),
    .MAX_GAP_CYC   (MAX_GAP_CYC),
    .FIRST_WAIT_CYC(FIRST_WAIT_CYC),
    .MAX_RETRIES   (MAX_RETRIES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .clkFall (clkFall),
    .dataNow (dataNow),
    .timer   (timer),
    .bitCnt  (bitCnt),
    .retryCnt(retryCnt),
    .ctl     (ctl),
    .ready   (ready),
    .done    (done),
    .fail    (fail),
    .clkOe   (ps2ClkOe)
  );

  ps2_tx_datapath #(
    .TW(TW),
    .RW(RW)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .txByte   (txByte),
    .ps2ClkIn (ps2ClkIn),
    .ps2DataIn(ps2DataIn),
    .clkFall  (clkFall),
    .dataNow  (dataNow),
    .timer    (timer),
    .bitCnt   (bitCnt),
    .retryCnt (retryCnt),
    .dataOe   (ps2DataOe)
  );

endmodule

// File: rtl/ps2_tx_checker.sv
module ps2_tx_checker #(
  parameter int unsigned INHIBIT_CYC = 200
) (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic done,
  input logic fail,
  input logic ps2ClkOe,
  input logic ps2DataOe
);

  logic [31:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else begin
      runLen <= ps2ClkOe ? runLen + 32'd1 : 32'd0;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!ps2ClkOe && !ps2DataOe));

  assert_inhibit_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ps2ClkOe) |-> (runLen == 32'(INHIBIT_CYC)));

  assert_inhibit_data_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    ps2ClkOe |-> !ps2DataOe);

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ps2ClkOe) |-> ps2DataOe);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && ready));

  assert_fail_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    fail |=> (!fail && !done && ready));

endmodule

bind ps2_host_tx ps2_tx_checker #(.INHIBIT_CYC(INHIBIT_CYC)) u_ps2TxChk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .done     (done),
  .fail     (fail),
  .ps2ClkOe (ps2ClkOe),
  .ps2DataOe(ps2DataOe)
);

// File: tb/test_ps2_host_tx.sv
module test_ps2_host_tx;

  localparam int CLK_PERIOD = 10;
  localparam int INH        = 20;
  localparam int BLANK      = 12;
  localparam int MINGAP     = 8;
  localparam int MAXGAP     = 40;
  localparam int FIRSTW     = 60;
  localparam int RETRIES    = 2;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic devClk = 1'b1;
  logic devData = 1'b1;
  logic ready, done, fail, ps2ClkOe, ps2DataOe;
  logic ps2ClkIn, ps2DataIn;

  assign ps2ClkIn  = devClk & ~ps2ClkOe;
  assign ps2DataIn = devData & ~ps2DataOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ps2_host_tx #(
    .INHIBIT_CYC   (INH),
    .BLANK_CYC     (BLANK),
    .MIN_GAP_CYC   (MINGAP),
    .MAX_GAP_CYC   (MAXGAP),
    .FIRST_WAIT_CYC(FIRSTW),
    .MAX_RETRIES   (RETRIES)
  ) i_ps2_host_tx (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .txByte   (txByte),
    .ready    (ready),
    .done     (done),
    .fail     (fail),
    .ps2ClkIn (ps2ClkIn),
    .ps2DataIn(ps2DataIn),
    .ps2ClkOe (ps2ClkOe),
    .ps2DataOe(ps2DataOe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event monitors, sampled on the falling system clock edge.
  int   attempts = 0, doneCnt = 0, failCnt = 0, runLen = 0, lastInh = 0, inhDataBad = 0;
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (ps2ClkOe && !prevOe) attempts++;
      if (ps2ClkOe) runLen++;
      else if (prevOe) begin
        lastInh = runLen;
        runLen  = 0;
      end
      if (ps2ClkOe && ps2DataOe) inhDataBad++;
      if (done) doneCnt++;
      if (fail) failCnt++;
      prevOe = ps2ClkOe;
    end
  end

  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [7:0] gotByte;
  logic gotPar, gotStop, startOk;
  int inhSeen, relCyc, lastFallCyc;

  task automatic sendByte(input logic [7:0] b);
    while (!ready) @(negedge clk);
    txByte   = b;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Device model: waits for the start bit, then clocks `edges` falling edges.
  task automatic serveAttempt(input bit nack, input int edges, input int glitch);
    while (ps2ClkOe || !ps2DataOe) @(negedge clk);
    relCyc = cyc;
    @(posedge clk);
    inhSeen = lastInh;
    @(negedge clk);
    if (glitch == 1) begin
      repeat (3) @(negedge clk);
      devClk = 1'b0;
      repeat (2) @(negedge clk);
      devClk = 1'b1;
      repeat (13) @(negedge clk);
    end else begin
      repeat (18) @(negedge clk);
    end
    startOk = ps2DataOe;
    gotByte = 8'h00;
    gotPar  = 1'b0;
    gotStop = 1'b0;
    for (int e = 1; e <= edges; e++) begin
      devClk      = 1'b0;
      lastFallCyc = cyc;
      if (glitch == 2 && e == 3) begin
        repeat (2) @(negedge clk);
        devClk = 1'b1;
        repeat (2) @(negedge clk);
        devClk = 1'b0;
        repeat (HALF - 4) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      devClk = 1'b1;
      if (e <= 8) gotByte[e-1] = ps2DataIn;
      else if (e == 9) gotPar = ps2DataIn;
      else if (e == 10) begin
        gotStop = ps2DataIn;
        devData = nack;
      end
      repeat (HALF) @(negedge clk);
      if (e == 11) devData = 1'b1;
    end
  endtask

  function automatic logic oddParity(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    return (ones % 2 == 0);
  endfunction

  task automatic checkFrame(input logic [7:0] b, input string tag);
    check(gotByte == b, "R4", {tag, " data bits"}, int'(gotByte), int'(b));
    check(gotPar == oddParity(b), "R5", {tag, " parity"}, int'(gotPar), int'(oddParity(b)));
    check(gotStop == 1'b1, "R6", {tag, " stop"}, int'(gotStop), 1);
    check(inhSeen == INH, "R2", {tag, " inhibit length"}, inhSeen, INH);
    check(startOk == 1'b1, "R3", {tag, " start bit held"}, int'(startOk), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", nChk - nBad, nChk);
      $finish;
    end
  end

  initial begin
    int a0, d0, f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    check(ps2ClkOe == 1'b0, "R1", "clock released", int'(ps2ClkOe), 0);
    check(ps2DataOe == 1'b0, "R1", "data released", int'(ps2DataOe), 0);
    check(done == 1'b0 && fail == 1'b0, "R1", "no pulses", int'({done, fail}), 0);

    // Sweep of every byte value with a well-behaved device (R2..R7)
    for (int b = 0; b < 256; b++) begin
      a0 = attempts; d0 = doneCnt;
      sendByte(8'(b));
      serveAttempt(1'b0, 11, 0);
      checkFrame(8'(b), "sweep");
      check(doneCnt - d0 == 1, "R7", "done pulse", doneCnt - d0, 1);
      check(attempts - a0 == 1, "R7", "single attempt", attempts - a0, 1);
      @(negedge clk);
      check(ready && !ps2ClkOe && !ps2DataOe, "R7", "idle after done",
            int'({ready, ps2ClkOe, ps2DataOe}), 4);
    end

    // Early edge right after the clock release (R8)
    a0 = attempts; d0 = doneCnt;
    sendByte(8'h3C);
    serveAttempt(1'b0, 11, 1);
    checkFrame(8'h3C, "R8 blank");
    check(attempts - a0 == 1 && doneCnt - d0 == 1, "R8", "glitch ignored", attempts - a0, 1);

    // Extra edge too close after an accepted one (R9)
    a0 = attempts; d0 = doneCnt;
    sendByte(8'hC3);
    serveAttempt(1'b0, 11, 2);
    checkFrame(8'hC3, "R9 gap");
    check(attempts - a0 == 1 && doneCnt - d0 == 1, "R9", "close edge ignored", attempts - a0, 1);

    // Negative acknowledge twice, then success (R10)
    a0 = attempts; d0 = doneCnt; f0 = failCnt;
    sendByte(8'h5A);
    for (int k = 0; k < 3; k++) begin
      serveAttempt(k < 2, 11, 0);
      checkFrame(8'h5A, "R10 retry");
    end
    check(attempts - a0 == 3, "R10", "attempt count", attempts - a0, 3);
    check(doneCnt - d0 == 1, "R10", "done after retries", doneCnt - d0, 1);
    check(failCnt == f0, "R10", "no fail", failCnt - f0, 0);

    // Retries exhausted (R12)
    a0 = attempts; d0 = doneCnt; f0 = failCnt;
    sendByte(8'h96);
    for (int k = 0; k <= RETRIES; k++) serveAttempt(1'b1, 11, 0);
    @(negedge clk);
    check(attempts - a0 == RETRIES + 1, "R12", "attempts before fail", attempts - a0, RETRIES + 1);
    check(failCnt - f0 == 1, "R12", "fail pulse", failCnt - f0, 1);
    check(doneCnt == d0, "R12", "no done", doneCnt - d0, 0);
    check(ready && !ps2ClkOe && !ps2DataOe, "R12", "idle after fail",
          int'({ready, ps2ClkOe, ps2DataOe}), 4);

    // Device stalls after four edges (R11)
    a0 = attempts; d0 = doneCnt;
    sendByte(8'h11);
    serveAttempt(1'b0, 4, 0);
    while (!ps2ClkOe) @(negedge clk);
    check((cyc - lastFallCyc) >= MAXGAP + 3 && (cyc - lastFallCyc) <= MAXGAP + 5, "R11",
          "gap timeout delay", cyc - lastFallCyc, MAXGAP + 4);
    serveAttempt(1'b0, 11, 0);
    checkFrame(8'h11, "R11 after gap");
    check(attempts - a0 == 2 && doneCnt - d0 == 1, "R11", "gap retry completes", attempts - a0, 2);

    // Device never clocks after release (R11)
    a0 = attempts; d0 = doneCnt;
    sendByte(8'h22);
    serveAttempt(1'b0, 0, 0);
    while (!ps2ClkOe) @(negedge clk);
    check((cyc - relCyc) >= FIRSTW && (cyc - relCyc) <= FIRSTW + 2, "R11",
          "first edge timeout delay", cyc - relCyc, FIRSTW + 1);
    serveAttempt(1'b0, 11, 0);
    checkFrame(8'h22, "R11 after first wait");
    check(attempts - a0 == 2 && doneCnt - d0 == 1, "R11", "first wait retry completes", attempts - a0, 2);

    // Request while busy is ignored (R13)
    a0 = attempts; d0 = doneCnt;
    sendByte(8'h0F);
    repeat (3) @(negedge clk);
    txByte   = 8'hF0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    serveAttempt(1'b0, 11, 0);
    check(gotByte == 8'h0F, "R13", "byte in flight kept", int'(gotByte), 15);
    repeat (100) @(negedge clk);
    check(attempts - a0 == 1 && doneCnt - d0 == 1, "R13", "no extra transfer", attempts - a0, 1);
    check(ready == 1'b1, "R13", "ready again", int'(ready), 1);

    check(inhDataBad == 0, "R2", "data free during inhibit", inhDataBad, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

endmodule